// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Expander

This block forms the second ALU operand for a 32-bit load-store datapath. It receives a 12-bit operand field from the instruction, the value already read from the register file and the current carry flag. A select bit picks one of two modes. In immediate mode, an 8-bit constant is widened to 32 bits and rotated right by twice a 4-bit count, so a small field can still express constants such as a byte placed at the top of the word. In register mode, the register value is shifted left, shifted right logically, shifted right arithmetically or rotated right by a 5-bit amount. Both modes also produce the shifter carry, which is the last bit moved out.

A separate widening path turns an 8-bit, 12-bit or 16-bit quantity into 32 bits with either zero fill or copies of its top bit. Load units and immediate decoders use it. The register index that selects the register source is passed through from the low four bits of the field, so the register-read stage can use it.

The block holds no state. Every output is a pure function of the current inputs and settles within one cycle of the surrounding pipeline.

Top module: `o2_operand_gen`

## Requirements
- R1: With `imm_sel`=1, `op2` equals `op_field[7:0]` zero-extended to 32 bits and then rotated right by 2 × `op_field[11:8]` bit positions.
- R2: With `imm_sel`=1 and a rotate count of 0, `op2` is the byte unchanged (0..255). Byte 0xFF with count 4 gives 0xFF000000.
- R3: With `imm_sel`=0 and `op_field[6:5]`=00, `op2` is `rm_val` shifted left by `op_field[11:7]` with zeros entering from bit 0.
- R4: With `imm_sel`=0 and `op_field[6:5]`=01, `op2` is `rm_val` shifted right by `op_field[11:7]` with zeros entering at bit 31.
- R5: With `imm_sel`=0 and `op_field[6:5]`=10, `op2` is `rm_val` shifted right by `op_field[11:7]` with copies of `rm_val[31]` entering at the top.
- R6: With `imm_sel`=0 and `op_field[6:5]`=11, `op2` is `rm_val` rotated right by `op_field[11:7]`.
- R7: With `imm_sel`=0 and a shift amount of 0, `op2` equals `rm_val` and `shift_carry` equals `carry_in` for every shift type.
- R8: With `imm_sel`=0 and a nonzero amount n, `shift_carry` is the last bit moved out. For a left shift that is `rm_val[32-n]`. For the other three types it is `rm_val[n-1]`.
- R9: With `imm_sel`=1, `shift_carry` equals `carry_in` when the rotate count is 0, and `op2[31]` otherwise.
- R10: `ext_out` takes the low 8 bits of `ext_val` (`ext_mode`=00), the low 16 bits (01 or 11) or the low 12 bits (10). With `ext_signed`=0 every bit above that width is 0, and the bits of `ext_val` above the width have no effect.
- R11: With `ext_signed`=1, every bit of `ext_out` above the chosen width copies the top bit of the narrow value. Byte 0xFF gives 0xFFFFFFFF, and 12-bit 0xFFF gives 0xFFFFFFFF.
- R12: The block is purely combinational: outputs follow an input change with no clock edge in between.
- R13: `reg_idx` always equals `op_field[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_sel | input | 1 | 1 selects rotated immediate, 0 selects shifted register |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the register source |
| carry_in | input | 1 | Current carry flag |
| ext_val | input | 16 | Narrow value for the widening path |
| ext_mode | input | 2 | Source width: 00 byte, 01 half, 10 twelve bits, 11 half |
| ext_signed | input | 1 | 1 fills with the top bit, 0 fills with zeros |
| op2 | output | 32 | Second operand |
| shift_carry | output | 1 | Shifter carry-out |
| reg_idx | output | 4 | Register source index |
| ext_out | output | 32 | Widened value |

## Verification
The assertions check several properties on every evaluation: a rotated immediate keeps the number of one bits in its byte, a zero rotate or zero amount passes the value and the carry through, a left shift leaves zeros in its low bits, a logical right shift leaves zeros at the top, an arithmetic shift keeps bit 31, and a widened result is filled uniformly above bit 15. Only the bench's vectors can show that data lands in the exact bit positions, that the carry comes from the correct bit for each shift type, and that high bits of `ext_val` outside the chosen width are ignored. Only the bench can show that outputs change between clock edges.

// File: rtl/o2_pkg.sv
package o2_pkg;

    localparam int OP2_W     = 32;
    localparam int FIELD_W   = 12;
    localparam int IMM_W     = 8;
    localparam int ROT_W     = 4;
    localparam int AMT_W     = $clog2(OP2_W);
    localparam int REG_IDX_W = 4;
    localparam int EXT_IN_W  = 16;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [OP2_W-1:0]     op2;
        logic                 carry;
        logic [REG_IDX_W-1:0] idx;
        logic [OP2_W-1:0]     ext;
    } o2_res_t;

endpackage

// File: rtl/o2_rot_imm.sv
module o2_rot_imm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  base,
    input  logic [ROT_W-1:0]  rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value,
    output logic              carry_out
);
    localparam int AMT_W = $clog2(DATA_W);

    logic [AMT_W-1:0]    amt;
    logic [DATA_W-1:0]   wide;
    logic [2*DATA_W-1:0] twice;

    always_comb begin
        amt       = AMT_W'(rot) << 1;
        wide      = DATA_W'(base);
        twice     = {wide, wide} >> amt;
        value     = twice[DATA_W-1:0];
        carry_out = (rot == '0) ? carry_in : value[DATA_W-1];
    end
endmodule

// File: rtl/o2_reg_shift.sv
module o2_reg_shift
    import o2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rm,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value,
    output logic              carry_out
);
    logic [DATA_W:0]     left_w;
    logic [DATA_W:0]     right_w;
    logic [DATA_W:0]     arith_w;
    logic [2*DATA_W-1:0] rot_w;

    always_comb begin
        left_w  = {1'b0, rm} << amt;
        right_w = {rm, 1'b0} >> amt;
        arith_w = $signed({rm, 1'b0}) >>> amt;
        rot_w   = {rm, rm} >> amt;
        unique case (kind)
            SH_LSL: begin
                value     = left_w[DATA_W-1:0];
                carry_out = left_w[DATA_W];
            end
            SH_LSR: begin
                value     = right_w[DATA_W:1];
                carry_out = right_w[0];
            end
            SH_ASR: begin
                value     = arith_w[DATA_W:1];
                carry_out = arith_w[0];
            end
            default: begin
                value     = rot_w[DATA_W-1:0];
                carry_out = right_w[0];
            end
        endcase
        if (amt == '0) begin
            value     = rm;
            carry_out = carry_in;
        end
    end
endmodule

// File: rtl/o2_width_ext.sv
module o2_width_ext #(
    parameter int DATA_W = 32,
    parameter int IN_W   = 16,
    parameter int W_BYTE = 8,
    parameter int W_HALF = 16,
    parameter int W_MID  = 12
) (
    input  logic [IN_W-1:0]   val,
    input  logic [1:0]        mode,
    input  logic              signed_en,
    output logic [DATA_W-1:0] out
);
    localparam int N_MODES = 4;

    function automatic int mode_width(input int m);
        case (m)
            0:       return W_BYTE;
            1:       return W_HALF;
            2:       return W_MID;
            default: return W_HALF;
        endcase
    endfunction

    logic [DATA_W-1:0] cand [N_MODES];

    for (genvar g = 0; g < N_MODES; g++) begin : g_mode
        localparam int NW = mode_width(g);
        logic [NW-1:0] narrow;
        logic          fill;
        assign narrow  = val[NW-1:0];
        assign fill    = signed_en & narrow[NW-1];
        assign cand[g] = {{(DATA_W-NW){fill}}, narrow};
    end

    assign out = cand[mode];
endmodule

// File: rtl/o2_operand_gen.sv
module o2_operand_gen
    import o2_pkg::*;
(
    input  logic                 imm_sel,
    input  logic [FIELD_W-1:0]   op_field,
    input  logic [OP2_W-1:0]     rm_val,
    input  logic                 carry_in,
    input  logic [EXT_IN_W-1:0]  ext_val,
    input  logic [1:0]           ext_mode,
    input  logic                 ext_signed,
    output logic [OP2_W-1:0]     op2,
    output logic                 shift_carry,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [OP2_W-1:0]     ext_out
);
    localparam int AMT_LSB  = FIELD_W - AMT_W;
    localparam int KIND_LSB = 5;

    logic [OP2_W-1:0] imm_val;
    logic             imm_c;
    logic [OP2_W-1:0] sh_val;
    logic             sh_c;
    logic [OP2_W-1:0] ext_w;
    o2_res_t          res_d;

    o2_rot_imm #(
        .DATA_W (OP2_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_rot (
        .base      (op_field[IMM_W-1:0]),
        .rot       (op_field[IMM_W+ROT_W-1:IMM_W]),
        .carry_in  (carry_in),
        .value     (imm_val),
        .carry_out (imm_c)
    );

    o2_reg_shift #(
        .DATA_W (OP2_W),
        .AMT_W  (AMT_W)
    ) u_shift (
        .rm        (rm_val),
        .kind      (shift_kind_e'(op_field[KIND_LSB+1:KIND_LSB])),
        .amt       (op_field[FIELD_W-1:AMT_LSB]),
        .carry_in  (carry_in),
        .value     (sh_val),
        .carry_out (sh_c)
    );

    o2_width_ext #(
        .DATA_W (OP2_W),
        .IN_W   (EXT_IN_W)
    ) u_ext (
        .val       (ext_val),
        .mode      (ext_mode),
        .signed_en (ext_signed),
        .out       (ext_w)
    );

    always_comb begin
        res_d       = '0;
        res_d.op2   = imm_sel ? imm_val : sh_val;
        res_d.carry = imm_sel ? imm_c : sh_c;
        res_d.idx   = op_field[REG_IDX_W-1:0];
        res_d.ext   = ext_w;
    end

    assign op2         = res_d.op2;
    assign shift_carry = res_d.carry;
    assign reg_idx     = res_d.idx;
    assign ext_out     = res_d.ext;
endmodule

// File: rtl/o2_operand_gen_chk.sv
module o2_operand_gen_chk (
    input logic        imm_sel,
    input logic [11:0] op_field,
    input logic [31:0] rm_val,
    input logic        carry_in,
    input logic        ext_signed,
    input logic [31:0] op2,
    input logic        shift_carry,
    input logic [31:0] ext_out
);
    logic [4:0] amt;
    logic [1:0] kind;
    assign amt  = op_field[11:7];
    assign kind = op_field[6:5];

    always_comb begin
        if (imm_sel && op_field[11:8] == 4'd0) begin
            p_imm_plain_r2: assert (op2 == 32'(op_field[7:0]) && shift_carry == carry_in)
                else $error("imm with zero rotate altered");
        end
        if (imm_sel) begin
            p_imm_ones_r1: assert ($countones(op2) == $countones(op_field[7:0]))
                else $error("rotation changed bit count");
        end
        if (!imm_sel && amt == 5'd0) begin
            p_zero_amt_r7: assert (op2 == rm_val && shift_carry == carry_in)
                else $error("zero shift altered value or carry");
        end
        if (!imm_sel && kind == 2'b00) begin
            p_lsl_fill_r3: assert ((op2 & ((32'd1 << amt) - 32'd1)) == 32'd0)
                else $error("left shift low bits not zero");
        end
        if (!imm_sel && kind == 2'b01) begin
            p_lsr_fill_r4: assert ((op2 & ~(32'hFFFF_FFFF >> amt)) == 32'd0)
                else $error("logical right shift top bits not zero");
        end
        if (!imm_sel && kind == 2'b10) begin
            p_asr_sign_r5: assert (op2[31] == rm_val[31])
                else $error("arithmetic shift lost sign");
        end
        if (!imm_sel && kind == 2'b11) begin
            p_ror_ones_r6: assert ($countones(op2) == $countones(rm_val))
                else $error("rotate changed bit count");
        end
        if (!ext_signed) begin
            p_ext_zero_r10: assert (ext_out[31:16] == 16'd0)
                else $error("zero fill left upper bits set");
        end
        if (ext_signed) begin
            p_ext_sign_r11: assert (ext_out[31:16] == {16{ext_out[15]}})
                else $error("sign fill not uniform");
        end
    end
endmodule

bind o2_operand_gen o2_operand_gen_chk u_chk (
    .imm_sel     (imm_sel),
    .op_field    (op_field),
    .rm_val      (rm_val),
    .carry_in    (carry_in),
    .ext_signed  (ext_signed),
    .op2         (op2),
    .shift_carry (shift_carry),
    .ext_out     (ext_out)
);

// File: tb/o2_operand_gen_test.sv
module o2_operand_gen_test;

    typedef struct packed {
        logic        imm;
        logic [11:0] fld;
        logic [31:0] rm;
        logic        cin;
        logic [31:0] exp_v;
        logic        exp_c;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h02A, 32'h0000_0000, 1'b1, 32'h0000_002A, 1'b1, 4'd2},  // R2 R9
        '{1'b1, 12'h4FF, 32'h0000_0000, 1'b0, 32'hFF00_0000, 1'b1, 4'd2},  // R2
        '{1'b1, 12'h103, 32'h0000_0000, 1'b0, 32'hC000_0000, 1'b1, 4'd1},  // R1
        '{1'b1, 12'hF81, 32'h0000_0000, 1'b1, 32'h0000_0204, 1'b0, 4'd9},  // R1 R9
        '{1'b0, 12'h203, 32'h1234_5678, 1'b0, 32'h2345_6780, 1'b1, 4'd3},  // R3 R8
        '{1'b0, 12'h080, 32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1, 4'd8},  // R3 R8
        '{1'b0, 12'h420, 32'hF000_00FF, 1'b0, 32'h00F0_0000, 1'b1, 4'd4},  // R4 R8
        '{1'b0, 12'h240, 32'h8000_0010, 1'b1, 32'hF800_0001, 1'b0, 4'd5},  // R5 R8
        '{1'b0, 12'hFC0, 32'h4000_0000, 1'b0, 32'h0000_0000, 1'b1, 4'd5},  // R5
        '{1'b0, 12'h460, 32'h1234_5678, 1'b1, 32'h7812_3456, 1'b0, 4'd6},  // R6 R8
        '{1'b0, 12'h020, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b1, 4'd7},  // R7
        '{1'b0, 12'h040, 32'h8000_0001, 1'b0, 32'h8000_0001, 1'b0, 4'd7},  // R7
        '{1'b0, 12'h0C0, 32'h7FFF_FFFF, 1'b0, 32'h3FFF_FFFF, 1'b1, 4'd5},  // R5
        '{1'b0, 12'hF80, 32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1, 4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        imm_sel = 1'b0;
    logic [11:0] op_field = '0;
    logic [31:0] rm_val = '0;
    logic        carry_in = 1'b0;
    logic [15:0] ext_val = '0;
    logic [1:0]  ext_mode = '0;
    logic        ext_signed = 1'b0;
    logic [31:0] op2;
    logic        shift_carry;
    logic [3:0]  reg_idx;
    logic [31:0] ext_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    o2_operand_gen uut (
        .imm_sel     (imm_sel),
        .op_field    (op_field),
        .rm_val      (rm_val),
        .carry_in    (carry_in),
        .ext_val     (ext_val),
        .ext_mode    (ext_mode),
        .ext_signed  (ext_signed),
        .op2         (op2),
        .shift_carry (shift_carry),
        .reg_idx     (reg_idx),
        .ext_out     (ext_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ext_case(input logic [15:0] v, input logic [1:0] m, input logic s,
                            input logic [31:0] exp, input string tag);
        @(negedge clk);
        ext_val = v; ext_mode = m; ext_signed = s;
        #5;
        chk(tag, ext_out, exp);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        #2;
        chk("R3 idle op2", op2, 32'h0);
        chk("R7 idle carry", {31'd0, shift_carry}, 32'h0);
        chk("R10 idle ext", ext_out, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            imm_sel  = VECS[i].imm;
            op_field = VECS[i].fld;
            rm_val   = VECS[i].rm;
            carry_in = VECS[i].cin;
            #5;
            chk($sformatf("R%0d vec %0d op2", VECS[i].req, i), op2, VECS[i].exp_v);
            chk($sformatf("R%0d vec %0d carry", VECS[i].req, i),
                {31'd0, shift_carry}, {31'd0, VECS[i].exp_c});
        end

        // R13: register index from low field bits
        @(negedge clk);
        imm_sel = 1'b0; op_field = 12'h20B;
        #5;
        chk("R13 idx", {28'd0, reg_idx}, 32'h0000_000B);

        // R12: change inputs just after a rising edge, sample before the next edge
        @(posedge clk);
        #2;
        imm_sel = 1'b1; op_field = 12'h4AB; carry_in = 1'b0;
        #2;
        chk("R12 comb op2", op2, 32'hAB00_0000);
        chk("R12 comb carry", {31'd0, shift_carry}, 32'h1);

        // R10 and R11: widening
        ext_case(16'h00FF, 2'b00, 1'b0, 32'h0000_00FF, "R10 byte zero");
        ext_case(16'h00FF, 2'b00, 1'b1, 32'hFFFF_FFFF, "R11 byte sign");
        ext_case(16'h007F, 2'b00, 1'b1, 32'h0000_007F, "R11 byte positive");
        ext_case(16'hAB80, 2'b00, 1'b1, 32'hFFFF_FF80, "R11 byte upper ignored");
        ext_case(16'hAB7F, 2'b00, 1'b0, 32'h0000_007F, "R10 byte upper ignored");
        ext_case(16'h8001, 2'b01, 1'b1, 32'hFFFF_8001, "R11 half sign");
        ext_case(16'h8001, 2'b01, 1'b0, 32'h0000_8001, "R10 half zero");
        ext_case(16'h0FFF, 2'b10, 1'b1, 32'hFFFF_FFFF, "R11 twelve minus one");
        ext_case(16'h07FF, 2'b10, 1'b1, 32'h0000_07FF, "R11 twelve positive");
        ext_case(16'hF800, 2'b10, 1'b0, 32'h0000_0800, "R10 twelve upper ignored");
        ext_case(16'hF800, 2'b10, 1'b1, 32'hFFFF_F800, "R11 twelve sign");
        ext_case(16'h8000, 2'b11, 1'b1, 32'hFFFF_8000, "R10 mode 11 half");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule